// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel Pair

This block holds a free-running up-counter with a programmable period and two compare channels that generate pulse-width-modulated outputs. Each channel can run on its own as a plain PWM output. The two channels can also be joined into one buffered PWM output, where their compare registers form a ping-pong pair. Software writes the next pulse width into the idle register. The hardware switches to that register exactly at the next period boundary, so a period never carries a half-updated width.

All configuration goes through a small write-only register port. The address map is: 0 timer control, 1 period (modulo), 2 channel-0 control, 3 channel-0 compare, 4 channel-1 control, 5 channel-1 compare. The counter position and a one-cycle overflow strobe come out on ports, so a system can line up its writes with the period.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset the counter reads 0 and is stopped, and `ovf_o`, `pwm0_o`, `pwm1_o` and `pin1_free_o` are all 0. The counter stays at 0 until software clears the stop bit.
- R2: While running, the counter steps 0,1,…,M and then returns to 0, where M is the period register (address 1). `ovf_o` is high for exactly the cycle in which the counter reads 0 after a wrap.
- R3: In the timer control register (address 0), bit 0 is a stored stop bit that freezes the counter. Bit 1 is a one-shot clear that zeroes the counter and prescaler in the cycle of the write and is not retained.
- R4: A channel control byte holds polarity in bits [1:0], toggle-on-overflow in bit 2 and mode in bits [4:3]. With mode 01, toggle set and polarity 10, the output is high for counter values below the compare value. With polarity 11 the output is inverted.
- R5: A compare value above M gives a constant pulse level (100% duty). A compare value of 0 gives a constant non-pulse level (0% duty), with no one-cycle pulse at the wrap.
- R6: Mode 10 in channel-0 control links the pair. The buffered output appears on `pwm0_o`, and channel-0's compare register sets the width until channel-1's compare register is written.
- R7: A write to the compare register that is not currently active leaves the current period's width unchanged and takes effect from the next wrap.
- R8: At each wrap, the width for the new period comes from whichever compare register, 0 or 1, was written most recently.
- R9: A write to the currently active compare register changes the width within the current period.
- R10: While the pair is linked, `pin1_free_o` is 1, `pwm1_o` is 0, and writes to channel-1 control are discarded. After unlinking, channel 1 still holds its earlier control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Register write data |
| cnt_o | output | CW | Current counter value |
| ovf_o | output | 1 | One-cycle strobe on counter wrap |
| pwm0_o | output | 1 | Channel-0 / buffered PWM output |
| pwm1_o | output | 1 | Channel-1 output, low while linked |
| pin1_free_o | output | 1 | Channel-1 pin released for general use |

## Verification
The bench targets the duty-cycle extremes. A compare of 0 must not leak a one-cycle pulse at the wrap, and a design that let the overflow action win over the match would show a glitch there. A compare above the period must stay at the pulse level for the whole period. In linked mode the bench writes compare registers in the middle of a period and measures whole periods. A design that switched registers at the write instead of at the wrap would shorten or stretch that period, and one that ignored write order would keep the old width. The bench also writes channel-1 control while the pair is linked, then unlinks. Any pulse on `pwm1_o` after that shows a write that should have been discarded.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
   // channel control byte, low five bits
   typedef struct packed {
      logic [1:0] mode;      // [4:3] 01 plain, 1x linked (channel 0 only)
      logic       tov;       // [2]   drive pulse level at wrap
      logic [1:0] pol;       // [1:0] 10 pulse high, 11 pulse low
   } chan_ctl_t;

   localparam logic [2:0] A_TCTL = 3'd0;
   localparam logic [2:0] A_MOD  = 3'd1;
   localparam logic [2:0] A_C0C  = 3'd2;
   localparam logic [2:0] A_C0V  = 3'd3;
   localparam logic [2:0] A_C1C  = 3'd4;
   localparam logic [2:0] A_C1V  = 3'd5;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CW      = 8,
   parameter int PRE_DIV = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stop,
   input  logic          clr,
   input  logic [CW-1:0] mod,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] cnt_nxt,
   output logic          adv,
   output logic          wrap,
   output logic          ovf
);
   localparam int PSW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   logic tick;

   generate
      if (PRE_DIV < 1) begin : g_bad_div
         $error("PRE_DIV must be at least 1");
      end
      if (PRE_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [PSW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pre_q <= '0;
            else if (clr)                        pre_q <= '0;
            else if (!stop) begin
               if (pre_q == PSW'(PRE_DIV - 1))   pre_q <= '0;
               else                              pre_q <= pre_q + 1'b1;
            end
         end
         assign tick = (pre_q == PSW'(PRE_DIV - 1));
      end
   endgenerate

   assign adv     = tick && !stop && !clr;
   assign wrap    = adv && (cnt >= mod);
   assign cnt_nxt = wrap ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         ovf <= wrap;
         if (clr)      cnt <= '0;
         else if (adv) cnt <= cnt_nxt;
      end
   end

   // R2
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (cnt == '0));
   // R3
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tmr_pingpong.sv
module tmr_pingpong (
   input  logic clk,
   input  logic rst_n,
   input  logic relink,
   input  logic wr_v0,
   input  logic wr_v1,
   input  logic wrap,
   output logic sel,
   output logic last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel  <= 1'b0;
         last <= 1'b0;
      end else if (relink) begin
         sel  <= 1'b0;
         last <= 1'b0;
      end else begin
         if (wr_v1)      last <= 1'b1;
         else if (wr_v0) last <= 1'b0;
         if (wrap)       sel  <= last;
      end
   end

   // R7
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap && !relink) |=> $stable(sel));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import pwm_pair_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          allow,
   input  chan_ctl_t     ctl,
   input  logic [CW-1:0] cmp,
   input  logic [CW-1:0] cnt_nxt,
   input  logic          adv,
   input  logic          wrap,
   output logic          out
);
   logic en, lvl;

   assign en  = allow && ctl.pol[1] && (ctl.mode != 2'b00);
   assign lvl = ~ctl.pol[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     out <= 1'b0;
      else if (!en)                   out <= 1'b0;
      else if (adv) begin
         if (cnt_nxt == cmp)          out <= ~lvl;
         else if (wrap && ctl.tov)    out <= lvl;
      end
   end

   // R5
   zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv && wrap && cmp == '0) |=> (out == $past(~lvl)));
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv) |=> $stable(out));
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
   import pwm_pair_pkg::*;
#(
   parameter int CW      = 8,
   parameter int PRE_DIV = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] cnt_o,
   output logic          ovf_o,
   output logic          pwm0_o,
   output logic          pwm1_o,
   output logic          pin1_free_o
);
   localparam int CTLW = $bits(chan_ctl_t);

   generate
      if (CW < CTLW) begin : g_bad_cw
         $error("CW must hold a channel control byte");
      end
   endgenerate

   logic          stop_q;
   logic [CW-1:0] mod_q, v0_q, v1_q;
   chan_ctl_t     c0_q, c1_q;
   logic          linked, clr, wr_c0, wr_c1, wr_v0, wr_v1;
   logic          adv, wrap, sel, last;
   logic [CW-1:0] cnt_nxt, cmp0_eff;

   assign linked = c0_q.mode[1];
   assign clr    = wr_en && wr_addr == A_TCTL && wr_data[1];
   assign wr_c0  = wr_en && wr_addr == A_C0C;
   assign wr_c1  = wr_en && wr_addr == A_C1C && !linked;
   assign wr_v0  = wr_en && wr_addr == A_C0V;
   assign wr_v1  = wr_en && wr_addr == A_C1V;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b1;
         mod_q  <= '1;
         v0_q   <= '0;
         v1_q   <= '0;
         c0_q   <= '0;
         c1_q   <= '0;
      end else begin
         if (wr_en && wr_addr == A_TCTL) stop_q <= wr_data[0];
         if (wr_en && wr_addr == A_MOD)  mod_q  <= wr_data;
         if (wr_v0) v0_q <= wr_data;
         if (wr_v1) v1_q <= wr_data;
         if (wr_c0) c0_q <= chan_ctl_t'(wr_data[CTLW-1:0]);
         if (wr_c1) c1_q <= chan_ctl_t'(wr_data[CTLW-1:0]);
      end
   end

   tmr_count #(.CW(CW), .PRE_DIV(PRE_DIV)) u_cnt (
      .clk(clk), .rst_n(rst_n), .stop(stop_q), .clr(clr), .mod(mod_q),
      .cnt(cnt_o), .cnt_nxt(cnt_nxt), .adv(adv), .wrap(wrap), .ovf(ovf_o)
   );

   tmr_pingpong u_pp (
      .clk(clk), .rst_n(rst_n), .relink(wr_c0), .wr_v0(wr_v0), .wr_v1(wr_v1),
      .wrap(wrap), .sel(sel), .last(last)
   );

   // at a wrap the new period already uses the register written last
   always_comb begin
      if (!linked)   cmp0_eff = v0_q;
      else if (wrap) cmp0_eff = last ? v1_q : v0_q;
      else           cmp0_eff = sel  ? v1_q : v0_q;
   end

   tmr_chan #(.CW(CW)) u_ch0 (
      .clk(clk), .rst_n(rst_n), .allow(1'b1), .ctl(c0_q), .cmp(cmp0_eff),
      .cnt_nxt(cnt_nxt), .adv(adv), .wrap(wrap), .out(pwm0_o)
   );

   tmr_chan #(.CW(CW)) u_ch1 (
      .clk(clk), .rst_n(rst_n), .allow(!linked), .ctl(c1_q), .cmp(v1_q),
      .cnt_nxt(cnt_nxt), .adv(adv), .wrap(wrap), .out(pwm1_o)
   );

   assign pin1_free_o = linked;

   // R10
   ch1_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      linked |=> $stable(c1_q));
endmodule

// File: tb/pwm_pair_timer_tb_top.sv
module pwm_pair_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] cnt_o;
   logic       ovf_o, pwm0_o, pwm1_o, pin1_free_o;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   pwm_pair_timer #(.CW(8), .PRE_DIV(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cnt_o(cnt_o), .ovf_o(ovf_o), .pwm0_o(pwm0_o),
      .pwm1_o(pwm1_o), .pin1_free_o(pin1_free_o)
   );

   // {period, compare, inverted}
   localparam logic [16:0] VEC [6] = '{
      {8'd9, 8'd4,  1'b0},
      {8'd9, 8'd0,  1'b0},
      {8'd9, 8'd12, 1'b0},
      {8'd9, 8'd9,  1'b1},
      {8'd5, 8'd3,  1'b1},
      {8'd7, 8'd0,  1'b1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_ovf();
      for (int k = 0; k < 400; k++) begin
         if (ovf_o) return;
         @(negedge clk);
      end
   endtask

   // starts on the sample where ovf_o is high, ends on the next such sample
   task automatic period(input int len, input bit dow, input logic [2:0] a,
                         input logic [7:0] d, output int h0, output int h1);
      h0 = 0; h1 = 0;
      for (int i = 0; i < len; i++) begin
         if (pwm0_o) h0++;
         if (pwm1_o) h1++;
         if (dow && i == 2) begin
            wr_en = 1'b1; wr_addr = a; wr_data = d;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int h0, h1, e0, e1;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cnt_o == 0 && !ovf_o && !pwm0_o && !pwm1_o && !pin1_free_o,
          "R1 reset outputs", {cnt_o, ovf_o, pwm0_o, pwm1_o, pin1_free_o}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(cnt_o == 0, "R1 stopped after reset", cnt_o, 0);

      // table walk: R2 R4 R5
      for (int v = 0; v < 6; v++) begin
         logic [7:0] m, c;
         logic       p;
         int         ep, eo;
         {m, c, p} = VEC[v];
         wr(3'd0, 8'h03);
         wr(3'd1, m);
         wr(3'd3, c);
         wr(3'd2, 8'd14 + {7'd0, p});
         wr(3'd0, 8'h00);
         wait_ovf();
         ep = 0; eo = 0;
         for (int i = 0; i < 2 * (m + 1); i++) begin
            if (pwm0_o !== ((cnt_o < c) ^ p)) ep++;
            if (ovf_o !== (cnt_o == 0) || cnt_o > m) eo++;
            @(negedge clk);
         end
         chk(ep == 0, (c == 0 || c > m) ? "R5 duty extreme" : "R4 pwm shape", ep, 0);
         chk(eo == 0, "R2 count and wrap strobe", eo, 0);
      end

      // R3 stop and one-shot clear
      wr(3'd0, 8'h01);
      held = cnt_o;
      repeat (5) @(negedge clk);
      chk(cnt_o == held, "R3 stop freezes", cnt_o, held);
      wr(3'd0, 8'h00);
      repeat (3) @(negedge clk);
      wr(3'd0, 8'h02);
      chk(cnt_o == 0, "R3 clear zeroes", cnt_o, 0);
      @(negedge clk);
      chk(cnt_o == 1, "R3 clear not kept", cnt_o, 1);

      // linked pair
      wr(3'd0, 8'h03);
      wr(3'd1, 8'd9);
      wr(3'd3, 8'd3);
      wr(3'd2, 8'd22);
      wr(3'd4, 8'd15);              // R10 must be discarded
      wr(3'd0, 8'h00);
      chk(pin1_free_o == 1, "R10 pin released", pin1_free_o, 1);
      wait_ovf();
      period(10, 0, 3'd0, 8'd0, h0, h1);
      chk(h0 == 3, "R6 channel 0 sets width", h0, 3);
      e1 = h1;
      period(10, 1, 3'd5, 8'd7, h0, h1);
      chk(h0 == 3, "R7 inactive write deferred", h0, 3);
      e1 += h1;
      period(10, 0, 3'd0, 8'd0, h0, h1);
      chk(h0 == 7, "R8 last written takes over", h0, 7);
      e1 += h1;
      period(10, 1, 3'd5, 8'd5, h0, h1);
      chk(h0 == 5, "R9 active write immediate", h0, 5);
      e1 += h1;
      period(10, 1, 3'd3, 8'd2, h0, h1);
      chk(h0 == 5, "R7 deferred back to channel 0", h0, 5);
      e1 += h1;
      period(10, 0, 3'd0, 8'd0, h0, h1);
      chk(h0 == 2, "R8 channel 0 written last", h0, 2);
      e1 += h1;
      chk(e1 == 0, "R10 pwm1 low while linked", e1, 0);

      // unlink: channel 1 control must still be the reset value
      wr(3'd2, 8'd14);
      chk(pin1_free_o == 0, "R10 pin reclaimed", pin1_free_o, 0);
      wait_ovf();
      period(10, 0, 3'd0, 8'd0, h0, h1);
      e0 = h0;
      chk(h1 == 0, "R10 channel 1 control write discarded", h1, 0);
      chk(e0 == 2, "R4 unbuffered after unlink", e0, 2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule